// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock line and the bus-condition timing for an I2C master. A higher-level controller gives it one command at a time: start, repeated start, stop, or a single bit slot that carries one data value. The block pulls the clock and data lines low through open-drain style enables. It watches the sampled clock pin and reports each finished command with a one-cycle done pulse. Byte shifting, acknowledge handling, addressing and arbitration belong to the controller above it.

Two configuration fields set the timing. A high-phase count always sets the clock high time. A low-phase count sets the clock low time and also every start, stop and bus-free interval. When the low-phase count is zero, the high-phase count takes its place. Each phase is the field value plus a fixed offset of five clocks. The block counts the high phase only after the pin reads high, so rise time and slave clock stretching add to the bit period and are never cut from it.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `cfg_low_i` nonzero, every low-period interval lasts `cfg_low_i + 5` clock cycles. These intervals are the SCL low phase, the start hold, the stop setup, the repeated-start setup and the bus-free time.
- R2: With `cfg_low_i` zero, every low-period interval lasts `cfg_high_i + 5` cycles.
- R3: After releasing SCL, the block keeps it released until `scl_i` reads 1. It then holds the high phase for `cfg_high_i + 5` cycles, so the released time is the pin delay plus that count.
- R4: Start is accepted only while the bus is idle. It drives `sda_oe_o`=1 with SCL released for one low period. It then drives `scl_oe_o`=1 and the bus is held.
- R5: Stop runs from the held state in four steps:
  - it drives both enables for one low period;
  - it releases SCL and waits for the pin to read high;
  - it keeps SDA low for one low period;
  - it releases SDA and stays idle for one low period before the block returns to idle.
- R6: Repeated start runs from the held state. It releases SDA while SCL stays low for one low period. It then releases SCL, waits for the pin to read high, and waits one more low period. After that it performs the start sequence.
- R7: A bit slot latches `bit_sda_i` at acceptance. It drives `sda_oe_o` = NOT that value through the low phase, the high phase and the following held state.
- R8: `busy_o` is 1 exactly while a command sequence runs. `done_o` is a single-cycle pulse in the first cycle after the sequence, and `busy_o` is 0 in that cycle.
- R9: A command that arrives while the block is busy is ignored. In the idle state only start is accepted. In the held state only repeated start, stop and bit are accepted, with priority in that order.
- R10: `cfg_err_o` is 1 while both configuration fields are zero. While it is 1, no command is accepted.
- R11: The configuration fields are captured when a command is accepted. Changing them during a sequence does not alter that sequence's timing.
- R12: After reset, both enables, `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_high_i | input | CW | High-phase count field |
| cfg_low_i | input | CW | Low-phase count field; 0 selects the high field |
| cmd_start_i | input | 1 | Start command pulse |
| cmd_rstart_i | input | 1 | Repeated start command pulse |
| cmd_stop_i | input | 1 | Stop command pulse |
| cmd_bit_i | input | 1 | Bit slot command pulse |
| bit_sda_i | input | 1 | Data value for the bit slot (0 drives SDA low) |
| scl_i | input | 1 | Sampled SCL pin level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Command sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Both timing fields are zero |

## Verification
The bench goes after the corner cases where a slip shows up as a changed segment length.

- **Pin-delay wait.** The bench varies the pin delay, including a long stretch. A design that counts the high phase from its own release, instead of from the pin going high, shortens the released segments.
- **Zero-low fallback.** With the low field zero, a design that ignores the fallback produces five-cycle low periods.
- **Mid-sequence reconfiguration.** The bench rewrites both fields while a bit slot runs. A design that reads the live fields then stretches or shrinks that slot.
- **Ignored commands and the error flag.** Commands arrive while busy, in the wrong bus state, and with both fields zero. A design that accepts any of them shows busy or enable activity at the ports where none belongs.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HELD,
    S_ST_HOLD,
    S_BIT_LOW,
    S_BIT_WAIT,
    S_BIT_HIGH,
    S_SP_LOW,
    S_SP_WAIT,
    S_SP_SETUP,
    S_SP_BUF,
    S_RS_LOW,
    S_RS_WAIT,
    S_RS_SETUP
  } tim_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_START,
    CMD_RSTART,
    CMD_STOP,
    CMD_BIT
  } tim_cmd_e;

endpackage

// File: rtl/i2c_tim_cfg.sv
// Captures timing fields on accept; lengths follow live fields in the accept cycle.
module i2c_tim_cfg #(
  parameter int CW  = 8,
  parameter int OFS = 5,
  parameter int LW  = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cfg_high_i,
  input  logic [CW-1:0] cfg_low_i,
  input  logic          latch_i,
  output logic [LW-1:0] low_len_o,
  output logic [LW-1:0] high_len_o,
  output logic          err_o
);
  localparam logic [LW-1:0] OFS_L = LW'(OFS);

  logic [CW-1:0] hi_q, lo_q, hi_s, lo_s, lo_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (latch_i) begin
      hi_q <= cfg_high_i;
      lo_q <= cfg_low_i;
    end
  end

  assign hi_s       = latch_i ? cfg_high_i : hi_q;
  assign lo_s       = latch_i ? cfg_low_i  : lo_q;
  assign lo_eff     = (lo_s != '0) ? lo_s : hi_s;
  assign low_len_o  = LW'(lo_eff) + OFS_L;
  assign high_len_o = LW'(hi_s) + OFS_L;
  assign err_o      = (cfg_high_i == '0) && (cfg_low_i == '0);
endmodule

// File: rtl/i2c_tim_cmd.sv
// Command gating: bus state, busy and config error decide acceptance.
module i2c_tim_cmd
  import i2c_tim_pkg::*;
(
  input  logic     idle_i,
  input  logic     held_i,
  input  logic     err_i,
  input  logic     start_i,
  input  logic     rstart_i,
  input  logic     stop_i,
  input  logic     bit_i,
  output tim_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if (!err_i) begin
      if (idle_i && start_i) begin
        cmd_o = CMD_START;
      end else if (held_i) begin
        if (rstart_i)    cmd_o = CMD_RSTART;
        else if (stop_i) cmd_o = CMD_STOP;
        else if (bit_i)  cmd_o = CMD_BIT;
      end
    end
  end
endmodule

// File: rtl/i2c_tim_cnt.sv
// Down counter: a phase loaded with n lasts n cycles, zero_o marks its last one.
module i2c_tim_cnt #(
  parameter int LW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  output logic          zero_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - LW'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LW'(1);
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_tim_pkg::*;
#(
  parameter int CW  = 8,
  parameter int OFS = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cfg_high_i,
  input  logic [CW-1:0] cfg_low_i,
  input  logic          cmd_start_i,
  input  logic          cmd_rstart_i,
  input  logic          cmd_stop_i,
  input  logic          cmd_bit_i,
  input  logic          bit_sda_i,
  input  logic          scl_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_err_o
);
  localparam int LW = CW + 1;

  tim_state_e    state_q, state_d;
  tim_cmd_e      cmd;
  logic          sda_q, sda_d;
  logic          done_q;
  logic          load, use_high, latch, zero;
  logic [LW-1:0] low_len, high_len;
  logic          idle, held;

  assign idle = (state_q == S_IDLE);
  assign held = (state_q == S_HELD);

  i2c_tim_cfg #(.CW(CW), .OFS(OFS), .LW(LW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_high_i (cfg_high_i),
    .cfg_low_i  (cfg_low_i),
    .latch_i    (latch),
    .low_len_o  (low_len),
    .high_len_o (high_len),
    .err_o      (cfg_err_o)
  );

  i2c_tim_cmd u_cmd (
    .idle_i   (idle),
    .held_i   (held),
    .err_i    (cfg_err_o),
    .start_i  (cmd_start_i),
    .rstart_i (cmd_rstart_i),
    .stop_i   (cmd_stop_i),
    .bit_i    (cmd_bit_i),
    .cmd_o    (cmd)
  );

  i2c_tim_cnt #(.LW(LW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (use_high ? high_len : low_len),
    .zero_o (zero)
  );

  always_comb begin
    state_d  = state_q;
    sda_d    = sda_q;
    load     = 1'b0;
    use_high = 1'b0;
    latch    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cmd == CMD_START) begin
          state_d = S_ST_HOLD;
          load    = 1'b1;
          latch   = 1'b1;
        end
      end
      S_HELD: begin
        unique case (cmd)
          CMD_RSTART: begin state_d = S_RS_LOW;  load = 1'b1; latch = 1'b1; end
          CMD_STOP:   begin state_d = S_SP_LOW;  load = 1'b1; latch = 1'b1; end
          CMD_BIT: begin
            state_d = S_BIT_LOW;
            load    = 1'b1;
            latch   = 1'b1;
            sda_d   = ~bit_sda_i;
          end
          default: ;
        endcase
      end
      S_ST_HOLD: if (zero) begin state_d = S_HELD; sda_d = 1'b1; end
      S_BIT_LOW: if (zero) state_d = S_BIT_WAIT;
      S_BIT_WAIT: begin
        if (scl_i) begin
          state_d  = S_BIT_HIGH;
          load     = 1'b1;
          use_high = 1'b1;
        end
      end
      S_BIT_HIGH: if (zero) state_d = S_HELD;
      S_SP_LOW:   if (zero) state_d = S_SP_WAIT;
      S_SP_WAIT:  if (scl_i) begin state_d = S_SP_SETUP; load = 1'b1; end
      S_SP_SETUP: if (zero) begin state_d = S_SP_BUF; load = 1'b1; end
      S_SP_BUF:   if (zero) state_d = S_IDLE;
      S_RS_LOW:   if (zero) state_d = S_RS_WAIT;
      S_RS_WAIT:  if (scl_i) begin state_d = S_RS_SETUP; load = 1'b1; end
      S_RS_SETUP: if (zero) begin state_d = S_ST_HOLD; load = 1'b1; end
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sda_q   <= sda_d;
      done_q  <= !idle && !held && (state_d == S_IDLE || state_d == S_HELD);
    end
  end

  always_comb begin
    unique case (state_q)
      S_HELD, S_BIT_LOW, S_SP_LOW, S_RS_LOW: scl_oe_o = 1'b1;
      default:                               scl_oe_o = 1'b0;
    endcase
    unique case (state_q)
      S_ST_HOLD, S_SP_LOW, S_SP_WAIT, S_SP_SETUP: sda_oe_o = 1'b1;
      S_HELD, S_BIT_LOW, S_BIT_WAIT, S_BIT_HIGH:  sda_oe_o = sda_q;
      default:                                    sda_oe_o = 1'b0;
    endcase
  end

  assign busy_o = !idle && !held;
  assign done_o = done_q;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_start_i,
  input logic cmd_rstart_i,
  input logic cmd_stop_i,
  input logic cmd_bit_i,
  input logic scl_i,
  input logic scl_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic cfg_err_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R8
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_start_i || cmd_rstart_i || cmd_stop_i || cmd_bit_i)); // R9
  AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !busy_o) |=> !busy_o); // R10
  AST_STRETCH_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !scl_oe_o && !scl_i) |=> !scl_oe_o); // R3
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_start_i  (cmd_start_i),
  .cmd_rstart_i (cmd_rstart_i),
  .cmd_stop_i   (cmd_stop_i),
  .cmd_bit_i    (cmd_bit_i),
  .scl_i        (scl_i),
  .scl_oe_o     (scl_oe_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/sim_i2c_scl_timer.sv
`timescale 1ns/1ps
module sim_i2c_scl_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_hi = 8'd3, cfg_lo = 8'd7;
  logic       c_start = 0, c_rstart = 0, c_stop = 0, c_bit = 0, bit_v = 0;
  logic       scl_pin = 1'b1;
  logic       scl_oe, sda_oe, busy, done, cfg_err;

  always #10 clk = ~clk;

  i2c_scl_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_high_i(cfg_hi), .cfg_low_i(cfg_lo),
    .cmd_start_i(c_start), .cmd_rstart_i(c_rstart), .cmd_stop_i(c_stop),
    .cmd_bit_i(c_bit), .bit_sda_i(bit_v), .scl_i(scl_pin),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .cfg_err_o(cfg_err)
  );

  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin model: pulled low at once, reads high rise_d cycles after release.
  int rise_d = 1;
  int rel_cnt = 100;
  always @(negedge clk) begin
    if (scl_oe) begin
      rel_cnt = 0;
      scl_pin = 1'b0;
    end else begin
      if (rel_cnt < rise_d) rel_cnt++;
      scl_pin = (rel_cnt >= rise_d);
    end
  end

  // Scoreboard: segments of {scl_oe, sda_oe, busy, done}; len < 0 = any length.
  typedef struct {
    logic [3:0] v;
    int         len;
    string      req;
  } seg_t;
  seg_t exp_q[$];

  task automatic push(input logic [3:0] v, input int len, input string req);
    seg_t s;
    s.v = v; s.len = len; s.req = req;
    exp_q.push_back(s);
  endtask

  bit         mon_en = 0;
  logic [3:0] cur_v = 4'b0000;
  int         cur_len = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      logic [3:0] v;
      v = {scl_oe, sda_oe, busy, done};
      if (v !== cur_v) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8 unexpected segment", int'(cur_v), -1);
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          chk(e.v === cur_v, {e.req, " vector"}, int'(cur_v), int'(e.v));
          if (e.len >= 0) chk(cur_len == e.len, {e.req, " length"}, cur_len, e.len);
        end
        cur_v = v;
        cur_len = 1;
      end else begin
        cur_len++;
      end
    end
  end

  function automatic int low_p();
    return ((cfg_lo != 0) ? int'(cfg_lo) : int'(cfg_hi)) + 5;
  endfunction
  function automatic int high_p();
    return int'(cfg_hi) + 5;
  endfunction

  task automatic pulse(input int which, input logic v);
    @(negedge clk);
    bit_v = v;
    case (which)
      0: c_start = 1;
      1: c_rstart = 1;
      2: c_stop = 1;
      default: c_bit = 1;
    endcase
    @(negedge clk);
    c_start = 0; c_rstart = 0; c_stop = 0; c_bit = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, {req, " done timeout"}, n, 3000);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_start(input string req);
    int l = low_p();
    push(4'b0110, l, {req, " R4 start hold"});
    push(4'b1101, 1, {req, " R8 done"});
    push(4'b1100, -1, "held");
    pulse(0, 0);
    wait_done(req);
  endtask

  task automatic do_bit(input logic v, input bit reconf, input string req);
    int         l = low_p();
    int         h = high_p();
    logic [7:0] sh = cfg_hi, sl = cfg_lo;
    logic       s = ~v;
    push({1'b1, s, 2'b10}, l, {req, " R7 bit low"});
    push({1'b0, s, 2'b10}, rise_d + h, {req, " R3 bit high"});
    push({1'b1, s, 2'b01}, 1, {req, " R8 done"});
    push({1'b1, s, 2'b00}, -1, "held");
    pulse(3, v);
    if (reconf) begin
      // R11: fields change mid-sequence, timing must stay
      repeat (3) @(negedge clk);
      cfg_hi = 8'd20; cfg_lo = 8'd1;
      // R9: stop and start while busy are ignored
      pulse(2, 0);
      pulse(0, 0);
    end
    wait_done(req);
    cfg_hi = sh; cfg_lo = sl;
  endtask

  task automatic do_stop(input string req);
    int l = low_p();
    push(4'b1110, l, {req, " R5 stop low"});
    push(4'b0110, rise_d + l, {req, " R5 stop setup"});
    push(4'b0010, l, {req, " R5 bus free"});
    push(4'b0001, 1, {req, " R8 done"});
    push(4'b0000, -1, "idle");
    pulse(2, 0);
    wait_done(req);
  endtask

  task automatic do_rstart(input string req);
    int l = low_p();
    push(4'b1010, l, {req, " R6 rs low"});
    push(4'b0010, rise_d + l, {req, " R6 rs setup"});
    push(4'b0110, l, {req, " R6 rs hold"});
    push(4'b1101, 1, {req, " R8 done"});
    push(4'b1100, -1, "held");
    pulse(1, 0);
    wait_done(req);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R12 enables after reset", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && done == 0, "R12 busy/done after reset", {busy, done}, 0);
    push(4'b0000, -1, "idle");
    mon_en = 1;

    // R1: low field nonzero
    do_start("R1 t1");
    do_bit(1'b1, 0, "R1 t1");
    rise_d = 3;
    do_bit(1'b0, 0, "R1 t1");
    do_rstart("R1 t1");
    rise_d = 7; // R3 clock stretch
    do_bit(1'b1, 0, "R3 t1");
    rise_d = 2;
    do_stop("R1 t1");

    // R2: low field zero falls back to high field
    cfg_hi = 8'd6; cfg_lo = 8'd0;
    do_start("R2 t2");
    do_bit(1'b0, 0, "R2 t2");
    do_stop("R2 t2");

    // R11 + R9: reconfigure and stray commands mid-bit
    cfg_hi = 8'd4; cfg_lo = 8'd9;
    do_start("R11 t3");
    do_bit(1'b1, 1, "R11 t3");

    // R9: start while held is ignored
    pulse(0, 0);
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0, "R9 start ignored when held", {busy, done}, 0);
    chk(scl_oe == 1, "R9 bus still held", scl_oe, 1);
    do_stop("R9 t3");

    // R9: bit and stop while idle are ignored
    pulse(3, 0);
    pulse(2, 0);
    repeat (4) @(negedge clk);
    chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R9 idle ignores bit/stop",
        {busy, scl_oe, sda_oe}, 0);

    // R10: both fields zero
    cfg_hi = 8'd0; cfg_lo = 8'd0;
    @(negedge clk);
    chk(cfg_err == 1, "R10 error flag set", cfg_err, 1);
    pulse(0, 0);
    repeat (5) @(negedge clk);
    chk(busy == 0 && sda_oe == 0 && scl_oe == 0, "R10 start refused",
        {busy, scl_oe, sda_oe}, 0);
    cfg_hi = 8'd2;
    @(negedge clk);
    chk(cfg_err == 0, "R10 error flag clears", cfg_err, 0);
    do_start("R10 t4");
    do_stop("R10 t4");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 1, "R8 scoreboard drained", exp_q.size(), 1);
    finish_run();
  end
endmodule